// File: doc/BRIEF.md
# Staggered Per-Round Nonce Counter Bank

This block feeds the nonce word to every round of a deeply pipelined hash datapath without carrying the nonce down the pipeline in a long shift register. It keeps one free-running counter for each round. Each counter is wired to the message input of the round that consumes the nonce, and its output is valid for the hash that is in that round during that cycle.

The counters stay in step because each one starts from a staggered value. The counter for round k is preloaded with the base nonce minus `OFFSETS[k]`, where `OFFSETS[k]` is the number of clock cycles between the nonce use in round zero and the nonce use in round k. The offsets follow the message schedule and are given as a parameter table. In the default table, round one uses the nonce 8 cycles after round zero and round two uses it 20 cycles after round zero. All offsets stay below the 96-cycle pipeline depth. After a load, all counters advance together on every enabled clock. Counter k therefore always shows the value that round zero showed `OFFSETS[k]` enabled cycles earlier.

Top module: `nonce_offset_bank`

## Requirements
- R1: During and after reset, lane k holds (0 - OFFSETS[k]) modulo 2^NONCE_W. This is the state a load with base zero would give.
- R2: If `load_i` is high at a clock edge, lane k holds (`base_i` - OFFSETS[k]) modulo 2^NONCE_W in the cycle that follows.
- R3: If `run_i` is high and `load_i` is low at a clock edge, every lane increases by exactly one.
- R4: If both `run_i` and `load_i` are low at a clock edge, every lane keeps its value.
- R5: If `load_i` and `run_i` are both high at a clock edge, the load wins. The lanes take base minus offset, with no increment added.
- R6: A lane that holds all ones and is incremented becomes zero. No flag or other side effect is produced.
- R7: In every cycle after reset or a load, lane k equals the value that lane 0 held OFFSETS[k] enabled cycles earlier. For cycles before the load, that earlier lane 0 value is taken as base minus the cycle distance.
- R8: Lane k occupies bits [k*NONCE_W +: NONCE_W] of `nonce_o`. Lane 0 has offset zero, so after a load it shows `base_i` exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Preload strobe for all lanes |
| base_i | input | NONCE_W | Round-zero nonce applied by a load |
| run_i | input | 1 | Advance all lanes by one |
| nonce_o | output | NUM_LANES*NONCE_W | Per-round nonce words, lane k at bits k*NONCE_W |

## Verification
The bench keeps a 96-entry history of the round-zero nonce. It checks every lane against the history tap at that lane's offset. This runs through long enabled stretches, through runs broken by idle cycles, and across reloads. Each pattern exposes a different fault: a wrong or swapped offset, a lane that drifts when the others hold, or a lane that adds one during a load.

Separate scenarios cover the following cases:
- a base of all ones, which makes lane 0 wrap while the other lanes do not, so a wrap that disturbs neighbouring lanes shows up;
- a small base, which makes the later lanes sit near the top of the range;
- a load and a run requested in the same cycle, which tells load priority apart from add-then-load.

// File: rtl/nonce_bank_pkg.sv
package nonce_bank_pkg;

    localparam int unsigned LANES_DEF   = 12;
    localparam int unsigned NONCE_W_DEF = 48;
    localparam int unsigned STEP_CYC    = 4;
    localparam int unsigned STEPS_PER_R = 2;
    localparam int unsigned PIPE_DEPTH  = STEP_CYC * STEPS_PER_R * LANES_DEF;

    typedef int unsigned offset_tab_t [LANES_DEF];

    localparam offset_tab_t OFFSETS_DEF =
        '{0, 8, 20, 26, 36, 44, 52, 60, 70, 78, 86, 94};

    typedef enum logic [1:0] {
        LANE_HOLD = 2'd0,
        LANE_STEP = 2'd1,
        LANE_SEED = 2'd2
    } lane_op_e;

    typedef struct packed {
        lane_op_e op;
    } lane_ctl_t;

    function automatic lane_op_e pick_op(input logic load, input logic run);
        if (load)
            return LANE_SEED;
        else if (run)
            return LANE_STEP;
        else
            return LANE_HOLD;
    endfunction

endpackage

// File: rtl/nonce_ctl.sv
module nonce_ctl
    import nonce_bank_pkg::*;
(
    input  logic      load_i,
    input  logic      run_i,
    output lane_ctl_t ctl_o
);
    always_comb begin
        ctl_o.op = pick_op(load_i, run_i);
    end
endmodule

// File: rtl/nonce_seed_gen.sv
module nonce_seed_gen #(
    parameter int unsigned NONCE_W = 48,
    parameter int unsigned OFFSET  = 0
) (
    input  logic [NONCE_W-1:0] base_i,
    output logic [NONCE_W-1:0] seed_o
);
    localparam logic [NONCE_W-1:0] OFF_W = NONCE_W'(OFFSET);

    always_comb begin
        seed_o = base_i - OFF_W;
    end
endmodule

// File: rtl/nonce_lane.sv
module nonce_lane
    import nonce_bank_pkg::*;
#(
    parameter int unsigned NONCE_W = 48,
    parameter int unsigned OFFSET  = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  lane_ctl_t          ctl_i,
    input  logic [NONCE_W-1:0] seed_i,
    output logic [NONCE_W-1:0] cnt_o
);
    localparam logic [NONCE_W-1:0] RST_VAL = '0 - NONCE_W'(OFFSET);
    localparam logic [NONCE_W-1:0] ONE     = NONCE_W'(1);

    logic [NONCE_W-1:0] cnt_q;
    logic [NONCE_W-1:0] cnt_d;

    always_comb begin
        unique case (ctl_i.op)
            LANE_SEED: cnt_d = seed_i;
            LANE_STEP: cnt_d = cnt_q + ONE;
            default:   cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= RST_VAL;
        else
            cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/nonce_offset_bank.sv
module nonce_offset_bank
    import nonce_bank_pkg::*;
#(
    parameter int unsigned NUM_LANES = LANES_DEF,
    parameter int unsigned NONCE_W   = NONCE_W_DEF,
    parameter int unsigned OFFSETS [NUM_LANES] = OFFSETS_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_i,
    input  logic [NONCE_W-1:0]           base_i,
    input  logic                         run_i,
    output logic [NUM_LANES*NONCE_W-1:0] nonce_o
);
    localparam int unsigned OUT_W = NUM_LANES * NONCE_W;

    lane_ctl_t ctl;

    nonce_ctl u_ctl (
        .load_i (load_i),
        .run_i  (run_i),
        .ctl_o  (ctl)
    );

    logic [NONCE_W-1:0] seed [NUM_LANES];
    logic [NONCE_W-1:0] cnt  [NUM_LANES];
    logic [OUT_W-1:0]   flat;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        nonce_seed_gen #(
            .NONCE_W (NONCE_W),
            .OFFSET  (OFFSETS[k])
        ) u_seed (
            .base_i (base_i),
            .seed_o (seed[k])
        );

        nonce_lane #(
            .NONCE_W (NONCE_W),
            .OFFSET  (OFFSETS[k])
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .ctl_i  (ctl),
            .seed_i (seed[k]),
            .cnt_o  (cnt[k])
        );

        assign flat[k*NONCE_W +: NONCE_W] = cnt[k];
    end

    assign nonce_o = flat;
endmodule

// File: rtl/nonce_offset_bank_chk.sv
module nonce_offset_bank_chk
    import nonce_bank_pkg::*;
#(
    parameter int unsigned NUM_LANES = LANES_DEF,
    parameter int unsigned NONCE_W   = NONCE_W_DEF,
    parameter int unsigned OFFSETS [NUM_LANES] = OFFSETS_DEF
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         load_i,
    input logic [NONCE_W-1:0]           base_i,
    input logic                         run_i,
    input logic [NUM_LANES*NONCE_W-1:0] nonce_o
);
    logic [NONCE_W-1:0] lane0;
    assign lane0 = nonce_o[NONCE_W-1:0];

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> lane0 == $past(base_i));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (run_i && !load_i) |=> lane0 == $past(lane0) + NONCE_W'(1));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !load_i) |=> $stable(nonce_o));

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (run_i && !load_i && (&lane0)) |=> lane0 == '0);

    for (genvar k = 1; k < NUM_LANES; k++) begin : g_gap
        p_gap_r7: assert property (@(posedge clk) disable iff (rst)
            !$isunknown(nonce_o) |->
            (lane0 - nonce_o[k*NONCE_W +: NONCE_W]) == NONCE_W'(OFFSETS[k]));
    end
endmodule

bind nonce_offset_bank nonce_offset_bank_chk #(
    .NUM_LANES (NUM_LANES),
    .NONCE_W   (NONCE_W),
    .OFFSETS   (OFFSETS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .base_i  (base_i),
    .run_i   (run_i),
    .nonce_o (nonce_o)
);

// File: tb/nonce_offset_bank_test.sv
`timescale 1ns/1ps
module nonce_offset_bank_test;
    import nonce_bank_pkg::*;

    localparam int unsigned L     = LANES_DEF;
    localparam int unsigned W     = NONCE_W_DEF;
    localparam int unsigned DEPTH = PIPE_DEPTH;
    localparam int unsigned OFF [L] = '{0, 8, 20, 26, 36, 44, 52, 60, 70, 78, 86, 94};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           load_i = 1'b0;
    logic [W-1:0]   base_i = '0;
    logic           run_i = 1'b0;
    logic [L*W-1:0] nonce_o;

    int total = 0;
    int bad   = 0;

    logic [W-1:0] hist [DEPTH];

    always #5 clk = ~clk;

    nonce_offset_bank uut (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .base_i  (base_i),
        .run_i   (run_i),
        .nonce_o (nonce_o)
    );

    function automatic logic [W-1:0] lane(input int k);
        return nonce_o[k*W +: W];
    endfunction

    task automatic model_seed(input logic [W-1:0] b);
        for (int j = 0; j < DEPTH; j++) hist[j] = b - W'(j);
    endtask

    task automatic model_step();
        for (int j = DEPTH - 1; j > 0; j--) hist[j] = hist[j-1];
        hist[0] = hist[1] + W'(1);
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R7/R8: every lane against the round-zero history tap at its offset
    task automatic check_taps(input string req);
        for (int k = 0; k < L; k++) check(req, lane(k), hist[OFF[k]]);
    endtask

    task automatic cycle(input logic ld, input logic [W-1:0] b, input logic en);
        load_i = ld; base_i = b; run_i = en;
        @(posedge clk);
        if (ld) model_seed(b);
        else if (en) model_step();
        @(negedge clk);
        load_i = 1'b0; run_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < L; k++) check("R1 reset", lane(k), '0 - W'(OFF[k]));
        rst = 1'b0;
        model_seed('0);
        cycle(1'b0, '0, 1'b0);
        check_taps("R1 after reset");
    endtask

    task automatic t_load();
        cycle(1'b1, 48'h0000_1234_5678, 1'b0);
        for (int k = 0; k < L; k++)
            check("R2 load", lane(k), 48'h0000_1234_5678 - W'(OFF[k]));
        check("R8 lane0 equals base", lane(0), 48'h0000_1234_5678);
    endtask

    task automatic t_run();
        logic [W-1:0] prev;
        for (int n = 0; n < 120; n++) begin
            prev = lane(3);
            cycle(1'b0, '0, 1'b1);
            check("R3 step", lane(3), prev + W'(1));
            check_taps("R7 run");
        end
    endtask

    task automatic t_hold();
        logic [L*W-1:0] snap;
        snap = nonce_o;
        for (int n = 0; n < 5; n++) begin
            cycle(1'b0, '0, 1'b0);
            for (int k = 0; k < L; k++) check("R4 hold", lane(k), snap[k*W +: W]);
        end
        for (int n = 0; n < 40; n++) begin
            cycle(1'b0, '0, (n % 3) != 0);
            check_taps("R7 gapped run");
        end
    endtask

    task automatic t_load_priority();
        cycle(1'b1, 48'hABCD_0000_0042, 1'b1);
        for (int k = 0; k < L; k++)
            check("R5 load over run", lane(k), 48'hABCD_0000_0042 - W'(OFF[k]));
    endtask

    task automatic t_wrap();
        cycle(1'b1, '1, 1'b0);
        check("R6 pre-wrap", lane(0), '1);
        cycle(1'b0, '0, 1'b1);
        check("R6 wrap to zero", lane(0), '0);
        check_taps("R6 wrap neighbours");
        for (int n = 0; n < 10; n++) begin
            cycle(1'b0, '0, 1'b1);
            check_taps("R7 after wrap");
        end
    endtask

    task automatic t_small_base();
        cycle(1'b1, 48'h0000_0000_0005, 1'b0);
        check("R2 small base lane11", lane(L-1), 48'h0000_0000_0005 - W'(OFF[L-1]));
        for (int n = 0; n < 100; n++) begin
            cycle(1'b0, '0, 1'b1);
            check_taps("R6 R7 upper lanes wrap");
        end
    endtask

    initial begin
        #(10 * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_run();
        t_hold();
        t_load_priority();
        t_wrap();
        t_small_base();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule